// File: doc/BRIEF.md
# Write-Invalidate Cache Line Controller (processor side)

This block is the processor-facing half of a snooping data cache. It keeps a direct-mapped array of one-word lines. Each line has a tag, a data word and a two-bit coherence state: invalid, shared (read only) or exclusive (read/write). Loads and stores from the processor are served from the array when the state allows it. Otherwise the block runs a short sequence of transactions on a shared bus before it answers the processor.

The processor holds `cpu_valid` with a stable address, direction and store data until `cpu_ready` is high at a clock edge. The low `IDX_W` bits of the word address select the line and the remaining bits form the tag. Bus transactions use a request/grant/done handshake. `bus_req` stays high for the whole sequence. A transaction ends in a cycle where both `bus_gnt` and `bus_done` are high, and `bus_rdata` carries the fill word in that cycle. Exclusive lines are write-back: they are copied to memory only when another address displaces them.

Top module: `wi_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, and `cpu_ready` and `bus_req` are low. The first access to any address therefore starts a bus transaction.
- R2: A load to an invalid line issues one transaction with code 2'b01 (read miss) at the load's address. It fills the line with `bus_rdata`, leaves the line shared and returns the fill word.
- R3: A load whose tag matches a shared or exclusive line raises `cpu_ready` in the cycle it is presented, returns the stored word, makes no bus request and leaves the state unchanged.
- R4: A load to an index that holds a shared line with another tag drops that line without write-back. It issues a single read miss and ends shared.
- R5: A load to an index that holds an exclusive line with another tag first issues code 2'b11 (write-back). That write-back carries the old address {old tag, index} and the old word. It then issues a read miss for the new address, and the line ends shared.
- R6: A store whose tag matches an exclusive line updates the word in place, stays exclusive and makes no bus request.
- R7: A store whose tag matches a shared line issues one transaction with code 2'b10 (write miss), then writes the store word and makes the line exclusive.
- R8: A store to an invalid line issues a write miss. The store word replaces the fill word and the line ends exclusive.
- R9: A store that conflicts with an exclusive line issues a write-back of the old line and then a write miss. A store that conflicts with a shared line issues only the write miss. Both end exclusive with the store word.
- R10: `cpu_ready` stays low from the miss until the last transaction of the sequence is done, and it is never high together with `bus_req`. `bus_req` stays high without a break from the first transaction to the last. The code and address are held stable until each transaction is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address: low IDX_W bits index, upper bits tag |
| cpu_wdata | input | DATA_W | Store word |
| cpu_rdata | output | DATA_W | Load word, valid with cpu_ready |
| cpu_ready | output | 1 | Request completes at this edge |
| bus_req | output | 1 | Bus wanted; held across a multi-transaction sequence |
| bus_op | output | 2 | 01 read miss, 10 write miss, 11 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back word |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Current transaction finishes (with grant) |
| bus_rdata | input | DATA_W | Fill word, sampled when the transaction finishes |

## Verification
The hardest case to reach is a two-transaction sequence. It needs an exclusive line whose tag differs from the one now requested at the same index, and that line can only be built by earlier accesses. The stimulus table first creates a shared line and upgrades it with a store. It then reads a conflicting tag, and later stores a third tag over a line made exclusive by a shared-hit store. The bench checks that the write-back carries the old address and word and that the request line never drops between the two transactions. A reset in the middle of the run then shows that lines left exclusive are forgotten.

// File: rtl/wi_cache_pkg.sv
package wi_cache_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'b00,
      LN_SHR = 2'b01,
      LN_EXC = 2'b10
   } line_state_e;

   typedef enum logic [1:0] {
      BOP_NONE   = 2'b00,
      BOP_RDMISS = 2'b01,
      BOP_WRMISS = 2'b10,
      BOP_WBACK  = 2'b11
   } bus_op_e;

   typedef enum logic [1:0] {
      ACT_RD_HIT      = 2'b00,
      ACT_WR_HIT      = 2'b01,
      ACT_FETCH       = 2'b10,
      ACT_EVICT_FETCH = 2'b11
   } access_act_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'b00,
      SQ_WB   = 2'b01,
      SQ_MISS = 2'b10
   } seq_state_e;

endpackage

// File: rtl/wi_line_store.sv
module wi_line_store
   import wi_cache_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int TAG_W  = 9,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output line_state_e       rd_state,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic              wr_fill,
   input  logic [IDX_W-1:0]  wr_idx,
   input  line_state_e       wr_state,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   localparam int LINES = 1 << IDX_W;

   line_state_e       st_arr  [LINES];
   logic [TAG_W-1:0]  tag_arr [LINES];
   logic [DATA_W-1:0] dat_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_state_e       st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] dat_q;
      logic              hit_w;

      assign hit_w = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     st_q <= LN_INV;
         else if (hit_w) st_q <= wr_state;
      end

      always_ff @(posedge clk) begin
         if (hit_w && wr_fill) begin
            tag_q <= wr_tag;
            dat_q <= wr_data;
         end
      end

      assign st_arr[g]  = st_q;
      assign tag_arr[g] = tag_q;
      assign dat_arr[g] = dat_q;
   end

   assign rd_state = st_arr[rd_idx];
   assign rd_tag   = tag_arr[rd_idx];
   assign rd_data  = dat_arr[rd_idx];

   always_ff @(posedge clk) begin
      if (rst_n && wr_en)
         assert_state_legal_R1: assert (wr_state != line_state_e'(2'b11))
            else $error("illegal line state written");
   end
endmodule

// File: rtl/wi_lookup.sv
module wi_lookup
   import wi_cache_pkg::*;
#(
   parameter int TAG_W = 9
) (
   input  line_state_e      line_st,
   input  logic [TAG_W-1:0] line_tag,
   input  logic [TAG_W-1:0] req_tag,
   input  logic             req_we,
   output access_act_e      act
);
   logic match;
   assign match = (line_st != LN_INV) && (line_tag == req_tag);

   always_comb begin
      if (match && !req_we)
         act = ACT_RD_HIT;
      else if (match && line_st == LN_EXC)
         act = ACT_WR_HIT;
      else if (!match && line_st == LN_EXC)
         act = ACT_EVICT_FETCH;
      else
         act = ACT_FETCH;
   end
endmodule

// File: rtl/wi_sequencer.sv
module wi_sequencer
   import wi_cache_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  access_act_e act,
   input  logic        xfer_done,
   output seq_state_e  sq
);
   seq_state_e sq_d;

   always_comb begin
      sq_d = sq;
      case (sq)
         SQ_IDLE: if (req_valid) begin
            if (act == ACT_EVICT_FETCH) sq_d = SQ_WB;
            else if (act == ACT_FETCH)  sq_d = SQ_MISS;
         end
         SQ_WB:   if (xfer_done) sq_d = SQ_MISS;
         SQ_MISS: if (xfer_done) sq_d = SQ_IDLE;
         default: sq_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sq <= SQ_IDLE;
      else        sq <= sq_d;
   end

   assert_wb_then_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sq == SQ_WB && xfer_done) |=> (sq == SQ_MISS))
      else $error("write-back not followed by miss");
endmodule

// File: rtl/wi_cache_ctrl.sv
module wi_cache_ctrl
   import wi_cache_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              bus_req,
   output logic [1:0]        bus_op,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_gnt,
   input  logic              bus_done,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (IDX_W < 1 || IDX_W >= ADDR_W) begin : g_bad_idx
      $error("IDX_W must be between 1 and ADDR_W-1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0]  idx;
   logic [TAG_W-1:0]  tag;
   line_state_e       l_st;
   logic [TAG_W-1:0]  l_tag;
   logic [DATA_W-1:0] l_data;
   access_act_e       act;
   seq_state_e        sq;
   logic              xfer_done;

   logic              wr_en, wr_fill;
   line_state_e       wr_state;
   logic [DATA_W-1:0] wr_data;

   assign idx       = cpu_addr[IDX_W-1:0];
   assign tag       = cpu_addr[ADDR_W-1:IDX_W];
   assign xfer_done = bus_req && bus_gnt && bus_done;

   wi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_store (
      .clk, .rst_n,
      .rd_idx  (idx),
      .rd_state(l_st),
      .rd_tag  (l_tag),
      .rd_data (l_data),
      .wr_en   (wr_en),
      .wr_fill (wr_fill),
      .wr_idx  (idx),
      .wr_state(wr_state),
      .wr_tag  (tag),
      .wr_data (wr_data)
   );

   wi_lookup #(.TAG_W(TAG_W)) i_lookup (
      .line_st (l_st),
      .line_tag(l_tag),
      .req_tag (tag),
      .req_we  (cpu_we),
      .act     (act)
   );

   wi_sequencer i_seq (
      .clk, .rst_n,
      .req_valid(cpu_valid),
      .act      (act),
      .xfer_done(xfer_done),
      .sq       (sq)
   );

   always_comb begin
      wr_en    = 1'b0;
      wr_fill  = 1'b0;
      wr_state = l_st;
      wr_data  = cpu_wdata;
      case (sq)
         SQ_IDLE: if (cpu_valid && act == ACT_WR_HIT) begin
            wr_en    = 1'b1;
            wr_fill  = 1'b1;
            wr_state = LN_EXC;
         end
         SQ_WB: if (xfer_done) begin
            wr_en    = 1'b1;
            wr_state = LN_INV;
         end
         SQ_MISS: if (xfer_done) begin
            wr_en    = 1'b1;
            wr_fill  = 1'b1;
            wr_state = cpu_we ? LN_EXC : LN_SHR;
            wr_data  = cpu_we ? cpu_wdata : bus_rdata;
         end
         default: ;
      endcase
   end

   assign cpu_ready = (sq == SQ_IDLE) && cpu_valid &&
                      (act == ACT_RD_HIT || act == ACT_WR_HIT);
   assign cpu_rdata = l_data;

   assign bus_req   = (sq != SQ_IDLE);
   assign bus_op    = (sq == SQ_WB)   ? BOP_WBACK :
                      (sq == SQ_MISS) ? (cpu_we ? BOP_WRMISS : BOP_RDMISS) : BOP_NONE;
   assign bus_addr  = (sq == SQ_WB) ? {l_tag, idx} : cpu_addr;
   assign bus_wdata = l_data;

   assert_ready_excl_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> !bus_req)
      else $error("ready during bus sequence");

   assert_req_coded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_op != 2'b00))
      else $error("bus request without transaction code");

   assert_hold_until_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !(bus_gnt && bus_done)) |=>
         (bus_req && $stable(bus_op) && $stable(bus_addr)))
      else $error("transaction changed before done");

   assert_wb_chains_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_op == 2'b11 && bus_gnt && bus_done) |=>
         (bus_req && bus_op != 2'b11))
      else $error("write-back not chained to miss");

   assert_miss_ends_seq_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_op != 2'b11 && bus_gnt && bus_done) |=> !bus_req)
      else $error("sequence continues after miss");
endmodule

// File: tb/test_wi_cache_ctrl.sv
`timescale 1ns/1ps
module test_wi_cache_ctrl;
   localparam int ADDR_W = 12;
   localparam int IDX_W  = 3;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_valid = 1'b0, cpu_we = 1'b0;
   logic [ADDR_W-1:0] cpu_addr = '0;
   logic [DATA_W-1:0] cpu_wdata = '0, cpu_rdata;
   logic              cpu_ready, bus_req;
   logic [1:0]        bus_op;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_wdata;
   logic              bus_gnt = 1'b0, bus_done = 1'b0;
   logic [DATA_W-1:0] bus_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   wi_cache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) i_wi_cache_ctrl (
      .clk, .rst_n, .cpu_valid, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_ready,
      .bus_req, .bus_op, .bus_addr, .bus_wdata, .bus_gnt, .bus_done, .bus_rdata
   );

   typedef struct packed {
      logic        we;
      logic [11:0] addr;
      logic [31:0] wdata;
      logic [31:0] fill;
      logic [1:0]  ntx;
      logic [1:0]  op0;
      logic [11:0] a0;
      logic [31:0] d0;
      logic [1:0]  op1;
      logic [11:0] a1;
      logic [31:0] rdata;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t TBL [NV] = '{
      '{1'b0, 12'h011, 32'h0,  32'hA1, 2'd1, 2'b01, 12'h011, 32'h0,  2'b00, 12'h000, 32'hA1}, // R2
      '{1'b0, 12'h011, 32'h0,  32'h0,  2'd0, 2'b00, 12'h000, 32'h0,  2'b00, 12'h000, 32'hA1}, // R3 shared
      '{1'b1, 12'h011, 32'hB1, 32'h0,  2'd1, 2'b10, 12'h011, 32'h0,  2'b00, 12'h000, 32'h0 }, // R7
      '{1'b1, 12'h011, 32'hB2, 32'h0,  2'd0, 2'b00, 12'h000, 32'h0,  2'b00, 12'h000, 32'h0 }, // R6
      '{1'b0, 12'h011, 32'h0,  32'h0,  2'd0, 2'b00, 12'h000, 32'h0,  2'b00, 12'h000, 32'hB2}, // R3 exclusive
      '{1'b0, 12'h019, 32'h0,  32'hC1, 2'd2, 2'b11, 12'h011, 32'hB2, 2'b01, 12'h019, 32'hC1}, // R5
      '{1'b1, 12'h019, 32'hD1, 32'h0,  2'd1, 2'b10, 12'h019, 32'h0,  2'b00, 12'h000, 32'h0 }, // R5 ends shared
      '{1'b1, 12'h021, 32'hE1, 32'h0,  2'd2, 2'b11, 12'h019, 32'hD1, 2'b10, 12'h021, 32'h0 }, // R9 exclusive victim
      '{1'b0, 12'h021, 32'h0,  32'h0,  2'd0, 2'b00, 12'h000, 32'h0,  2'b00, 12'h000, 32'hE1}, // R9
      '{1'b1, 12'h021, 32'hE2, 32'h0,  2'd0, 2'b00, 12'h000, 32'h0,  2'b00, 12'h000, 32'h0 }, // R9 ends exclusive
      '{1'b0, 12'h005, 32'h0,  32'hF1, 2'd1, 2'b01, 12'h005, 32'h0,  2'b00, 12'h000, 32'hF1}, // R2
      '{1'b0, 12'h00D, 32'h0,  32'hF2, 2'd1, 2'b01, 12'h00D, 32'h0,  2'b00, 12'h000, 32'hF2}, // R4
      '{1'b1, 12'h015, 32'h61, 32'h0,  2'd1, 2'b10, 12'h015, 32'h0,  2'b00, 12'h000, 32'h0 }, // R9 shared victim
      '{1'b0, 12'h015, 32'h0,  32'h0,  2'd0, 2'b00, 12'h000, 32'h0,  2'b00, 12'h000, 32'h61}, // R9
      '{1'b1, 12'h032, 32'h71, 32'hDEAD, 2'd1, 2'b10, 12'h032, 32'h0, 2'b00, 12'h000, 32'h0 }, // R8
      '{1'b0, 12'h032, 32'h0,  32'h0,  2'd0, 2'b00, 12'h000, 32'h0,  2'b00, 12'h000, 32'h71}, // R8 store word kept
      '{1'b1, 12'h032, 32'h72, 32'h0,  2'd0, 2'b00, 12'h000, 32'h0,  2'b00, 12'h000, 32'h0 }  // R8 ends exclusive
   };

   function automatic string vec_req(int i);
      case (i)
         0, 10:       return "R2";
         1, 4:        return "R3";
         2:           return "R7";
         3:           return "R6";
         5, 6:        return "R5";
         11:          return "R4";
         14, 15, 16:  return "R8";
         default:     return "R9";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   int          n_tx, gaps, overlap;
   logic [1:0]  r_op   [2];
   logic [11:0] r_addr [2];
   logic [31:0] r_data [2];
   logic [31:0] got_rd;
   bit          got;

   // called just after a falling edge
   task automatic access(input logic we, input logic [11:0] addr,
                         input logic [31:0] wd, input logic [31:0] fill);
      n_tx = 0; gaps = 0; overlap = 0; got = 0; got_rd = '0;
      for (int k = 0; k < 2; k++) begin r_op[k] = '0; r_addr[k] = '0; r_data[k] = '0; end
      cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      for (int c = 0; c < 40; c++) begin
         #1;
         if (cpu_ready && bus_req) overlap++;
         if (cpu_ready) begin
            got_rd = cpu_rdata;
            got = 1;
            break;
         end
         if (bus_req) begin
            if (n_tx < 2) begin
               r_op[n_tx] = bus_op; r_addr[n_tx] = bus_addr; r_data[n_tx] = bus_wdata;
            end
            n_tx++;
            bus_gnt = 1'b1; bus_done = 1'b1; bus_rdata = fill;
         end else if (n_tx > 0) begin
            gaps++;
         end
         @(negedge clk);
         bus_gnt = 1'b0; bus_done = 1'b0;
      end
      @(negedge clk);
      cpu_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #100000;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      @(negedge clk);
      #1;
      // R1: outputs idle during reset
      check(!cpu_ready && !bus_req, "R1", "ready/req in reset", {cpu_ready, bus_req}, 0);
      do_reset();
      #1;
      check(!cpu_ready && !bus_req, "R1", "ready/req after reset", {cpu_ready, bus_req}, 0);
      @(negedge clk);

      // R1: untouched line misses
      access(1'b0, 12'h007, '0, 32'h5A);
      check(n_tx == 1 && r_op[0] == 2'b01, "R1", "first read op", r_op[0], 2'b01);
      check(got && got_rd == 32'h5A, "R1", "first read data", got_rd, 32'h5A);

      for (int i = 0; i < NV; i++) begin
         access(TBL[i].we, TBL[i].addr, TBL[i].wdata, TBL[i].fill);
         check(got, vec_req(i), $sformatf("v%0d completion", i), got, 1);
         check(n_tx == int'(TBL[i].ntx), vec_req(i), $sformatf("v%0d transaction count", i),
               n_tx, TBL[i].ntx);
         if (TBL[i].ntx >= 1) begin
            check(r_op[0] == TBL[i].op0, vec_req(i), $sformatf("v%0d first op", i), r_op[0], TBL[i].op0);
            check(r_addr[0] == TBL[i].a0, vec_req(i), $sformatf("v%0d first addr", i), r_addr[0], TBL[i].a0);
            if (TBL[i].op0 == 2'b11)
               check(r_data[0] == TBL[i].d0, vec_req(i), $sformatf("v%0d write-back data", i),
                     r_data[0], TBL[i].d0);
         end
         if (TBL[i].ntx == 2) begin
            check(r_op[1] == TBL[i].op1, vec_req(i), $sformatf("v%0d second op", i), r_op[1], TBL[i].op1);
            check(r_addr[1] == TBL[i].a1, vec_req(i), $sformatf("v%0d second addr", i), r_addr[1], TBL[i].a1);
         end
         if (!TBL[i].we)
            check(got_rd == TBL[i].rdata, vec_req(i), $sformatf("v%0d read data", i), got_rd, TBL[i].rdata);
         // R10: no break in request, no ready during sequence
         check(gaps == 0 && overlap == 0, "R10", $sformatf("v%0d request gap/overlap", i),
               gaps + overlap, 0);
      end

      // R1: reset mid-run forgets an exclusive line (no write-back afterwards)
      do_reset();
      access(1'b0, 12'h021, '0, 32'h99);
      check(n_tx == 1 && r_op[0] == 2'b01, "R1", "post-reset read op", r_op[0], 2'b01);
      check(got_rd == 32'h99, "R1", "post-reset read data", got_rd, 32'h99);

      // R10: ready stays low while a delayed transaction waits for done
      access(1'b1, 12'h029, 32'h44, 32'h0);
      check(r_op[0] == 2'b10 && n_tx == 1, "R10", "write miss after delay setup", r_op[0], 2'b10);
      cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = 12'h031; cpu_wdata = '0;
      @(negedge clk);
      repeat (3) begin
         #1;
         check(bus_req && !cpu_ready && bus_op == 2'b11, "R10", "held write-back before done",
               {bus_req, cpu_ready, bus_op}, 4'b1011);
         check(bus_addr == 12'h029 && bus_wdata == 32'h44, "R5", "held write-back addr",
               bus_addr, 12'h029);
         bus_gnt = 1'b1;
         @(negedge clk);
      end
      #1; bus_done = 1'b1;
      @(negedge clk); bus_done = 1'b0;
      #1;
      check(bus_req && !cpu_ready && bus_op == 2'b01, "R10", "miss follows write-back",
            {bus_req, cpu_ready, bus_op}, 4'b1001);
      bus_done = 1'b1; bus_rdata = 32'h55;
      @(negedge clk); bus_done = 1'b0; bus_gnt = 1'b0;
      #1;
      check(cpu_ready && !bus_req && cpu_rdata == 32'h55, "R10", "ready after last done",
            cpu_rdata, 32'h55);
      @(negedge clk); cpu_valid = 1'b0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule